// File: doc/BRIEF.md
# Emergency Input Request Detector

This block monitors a small group of active-low emergency shutdown inputs. Each input can be set at run time to react to a single falling edge, or to require a sustained low level before a request is accepted. In level mode the input is sampled on a slow strobe, and sixteen low samples in a row qualify a request. The strobe comes from one shared prescaler and runs at the peripheral clock divided by 8, 16 or 128.

Every accepted request sets a sticky flag for its input. One interrupt line reports that at least one flag is set, and a single enable bit gates that line. Software reads and writes the block through two registers on a simple single-cycle port: a control register and a flag register. A flag clears only through an explicit read-then-write sequence, so a request cannot be lost.

Top module: `emg_input_detect`

## Requirements
- R1: With mode code 2'b00 (edge mode), a falling edge on an input, after it passes through a two-flop synchronizer, sets that input's flag.
- R2: With mode code 2'b01, the synchronized input is sampled once every 8 clocks, and the flag sets when 16 samples in a row are low.
- R3: With mode code 2'b10, the same 16-low-samples rule applies, with one sample every 16 clocks.
- R4: With mode code 2'b11, the same 16-low-samples rule applies, with one sample every 128 clocks.
- R5: A high sample returns the run count to zero. The count stops at 16 while the input stays low, so a held-low input raises only one request.
- R6: Each input has its own mode field, at control bits [2i+1:2i] for input i, so the inputs may run in different modes at once.
- R7: `irq` is high exactly when the enable bit (control bit 15) is 1 and any flag is 1. Flags still set while the enable bit is 0.
- R8: Control bits that are neither a mode field nor bit 15 read as 0 and ignore writes. Flag register bits at or above the number of inputs read as 0.
- R9: Flag i (bit i at address 1) clears only when software writes 0 to bit i after having read that flag as 1. Writing 1, or writing 0 with no earlier read of 1, leaves the flag unchanged.
- R10: If a new request arrives in the same cycle as a valid clear, the flag stays set.
- R11: Writing a new mode for an input resets that input's run count and suppresses edge detection for that cycle, so the switch itself never creates a request.
- R12: After reset, the control register reads 0, the flag register reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_n | input | NUM_PINS | Active-low emergency inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; arms flag clearing |
| reg_addr | input | 1 | 0 = control register, 1 = flag register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `pin_n` enters through the synchronizer and that no register write coincides with a read. They also assume that `reg_addr` is stable while a strobe is high. The stimulus changes pins and strobes only on the falling clock edge, and it issues reads and writes as separate single-cycle operations. Level-mode tests hold the inputs for durations chosen well clear of the 16-sample threshold. The one exception is the set-versus-clear collision, which is timed to the exact cycle by counting the synchronizer stages.

// File: rtl/emg_pkg.sv
// Package: shared encodings for the emergency input request detector.
// Assumes a 16-bit register port with two addresses.
package emg_pkg;
    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_DIV_A = 2'b01,
        MODE_DIV_B = 2'b10,
        MODE_DIV_C = 2'b11
    } pin_mode_e;

    localparam int   REG_W     = 16;
    localparam int   IE_BIT    = 15;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;
endpackage

// File: rtl/emg_prescaler.sv
// Module: free-running prescaler producing three one-cycle sample strobes.
// Assumes DIV_A, DIV_B and DIV_C are powers of two with DIV_C the largest,
// so each strobe fires when the low bits of one shared counter are all ones.
module emg_prescaler #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16,
    parameter int DIV_C = 128
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb_a,
    output logic stb_b,
    output logic stb_c
);
    localparam int CW = $clog2(DIV_C);
    localparam int AW = $clog2(DIV_A);
    localparam int BW = $clog2(DIV_B);

    logic [CW-1:0] cnt;

    // Purpose: advance the shared divider every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign stb_a = &cnt[AW-1:0];
    assign stb_b = &cnt[BW-1:0];
    assign stb_c = &cnt;
endmodule

// File: rtl/emg_pin_detect.sv
// Module: per-input request detector.
// Synchronizes one active-low input and detects either a falling edge or
// RUN consecutive low samples on the selected strobe. Produces a one-cycle
// request pulse. Assumes the strobes are one-cycle pulses.
module emg_pin_detect
    import emg_pkg::*;
#(
    parameter int RUN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_n,
    input  logic [1:0] mode,
    input  logic       stb_a,
    input  logic       stb_b,
    input  logic       stb_c,
    output logic       req
);
    localparam int            CW   = $clog2(RUN + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN);
    localparam logic [CW-1:0] LAST = CW'(RUN - 1);

    logic          sync1, sync2, prev;
    logic [1:0]    mode_q;
    logic [CW-1:0] cnt;
    logic          mode_chg, level, stb_sel, fall, qual;

    assign mode_chg = (mode != mode_q);
    assign level    = (mode != MODE_EDGE);

    // Purpose: choose the sample strobe that matches the current mode.
    always_comb begin
        case (mode)
            MODE_DIV_A: stb_sel = stb_a;
            MODE_DIV_B: stb_sel = stb_b;
            MODE_DIV_C: stb_sel = stb_c;
            default:    stb_sel = 1'b0;
        endcase
    end

    // Purpose: two-flop synchronizer and edge history, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            prev  <= 1'b1;
        end else begin
            sync1 <= pin_n;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Purpose: remember the last mode so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_EDGE;
        else        mode_q <= mode;
    end

    // Purpose: consecutive-low counter with restart and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (mode_chg || !level) begin
            cnt <= '0;
        end else if (stb_sel) begin
            if (sync2)             cnt <= '0;
            else if (cnt != FULL)  cnt <= cnt + 1'b1;
        end
    end

    assign fall = !level && !mode_chg && prev && !sync2;
    assign qual = level && !mode_chg && stb_sel && !sync2 && (cnt == LAST);
    assign req  = fall || qual;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);                                                   // R5
    AST_HIGH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (level && !mode_chg && stb_sel && sync2) |=> (cnt == '0));     // R5
    AST_MODE_CHG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (cnt == '0));                                     // R11
    AST_EDGE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && !mode_chg && $fell(sync2)) |-> req);                // R1
endmodule

// File: rtl/emg_regs.sv
// Module: control and flag registers with sticky flags and interrupt gating.
// Control layout: input i mode at [2i+1:2i], enable at bit IE_BIT. Flags at
// [NUM_PINS-1:0]. Assumes 2*NUM_PINS <= IE_BIT and that read and write
// strobes never coincide.
module emg_regs
    import emg_pkg::*;
#(
    parameter int NUM_PINS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic                  reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [NUM_PINS-1:0]   req,
    output logic [2*NUM_PINS-1:0] modes,
    output logic                  irq
);
    localparam int MW = 2 * NUM_PINS;

    logic                ie_q;
    logic [NUM_PINS-1:0] flags, armed;
    logic                wr_ctrl, wr_flag, rd_flag;
    logic                unused_wdata;

    assign wr_ctrl      = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_flag      = reg_wr && (reg_addr == ADDR_FLAG);
    assign rd_flag      = reg_rd && (reg_addr == ADDR_FLAG);
    assign unused_wdata = ^reg_wdata;

    // Purpose: control register holding mode fields and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modes <= '0;
            ie_q  <= 1'b0;
        end else if (wr_ctrl) begin
            modes <= reg_wdata[MW-1:0];
            ie_q  <= reg_wdata[IE_BIT];
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_flag
        logic clr;
        assign clr = wr_flag && !reg_wdata[i] && armed[i];

        // Purpose: sticky flag where a new request beats a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (req[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
        end

        // Purpose: remember that software has seen this flag set.
        always_ff @(posedge clk) begin
            if (!rst_n)                  armed[i] <= 1'b0;
            else if (clr || !flags[i])   armed[i] <= 1'b0;
            else if (rd_flag)            armed[i] <= 1'b1;
        end
    end

    // Purpose: read mux, with unused and reserved bits forced to zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[MW-1:0]  = modes;
            reg_rdata[IE_BIT]  = ie_q;
        end else begin
            reg_rdata[NUM_PINS-1:0] = flags;
        end
    end

    assign irq = ie_q && (|flags);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> (($past(flags) & ~flags) == '0));                  // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> ((flags & $past(req)) == $past(req)));             // R10
    AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (armed == '0) |=> (($past(flags) & ~flags) == '0));            // R9
endmodule

// File: rtl/emg_input_detect.sv
// Module: top of the emergency input request detector.
// Ties one shared prescaler, one detector per input and the register block
// together. Assumes pin_n is asynchronous and the register port is synchronous.
module emg_input_detect
    import emg_pkg::*;
#(
    parameter int NUM_PINS = 3,
    parameter int RUN      = 16,
    parameter int DIV_A    = 8,
    parameter int DIV_B    = 16,
    parameter int DIV_C    = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic                reg_addr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    output logic                irq
);
    logic                  stb_a, stb_b, stb_c;
    logic [NUM_PINS-1:0]   req;
    logic [2*NUM_PINS-1:0] modes;

    emg_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_presc (
        .clk(clk), .rst_n(rst_n), .stb_a(stb_a), .stb_b(stb_b), .stb_c(stb_c)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        emg_pin_detect #(.RUN(RUN)) u_det (
            .clk(clk), .rst_n(rst_n), .pin_n(pin_n[i]),
            .mode(modes[2*i +: 2]),
            .stb_a(stb_a), .stb_b(stb_b), .stb_c(stb_c),
            .req(req[i])
        );
    end

    emg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req(req), .modes(modes), .irq(irq)
    );
endmodule

// File: tb/tb_emg_input_detect.sv
module tb_emg_input_detect;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] low;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 16'd3,    1'b1},
        '{2'b01, 16'd100,  1'b0},
        '{2'b01, 16'd140,  1'b1},
        '{2'b10, 16'd230,  1'b0},
        '{2'b10, 16'd280,  1'b1},
        '{2'b11, 16'd1800, 1'b0},
        '{2'b11, 16'd2200, 1'b1},
        '{2'b00, 16'd1,    1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_n = '1;
    logic          reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          irq;
    int            checks = 0, errors = 0;
    logic [15:0]   rv;

    emg_input_detect dut (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_all();
        logic [15:0] t;
        rd(1'b1, t);
        wr(1'b1, 16'h0000);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R12 reset state
        rd(1'b0, rv); chk("R12 ctrl", rv, 16'h0000);
        rd(1'b1, rv); chk("R12 flags", rv, 16'h0000);
        #1 chk("R12 irq", {15'd0, irq}, 16'h0000);

        // R8 reserved bits
        wr(1'b0, 16'hFFFF);
        rd(1'b0, rv); chk("R8 ctrl reserved", rv, 16'h803F);
        wr(1'b0, 16'h0000);
        rd(1'b1, rv); chk("R8 flag upper", rv & 16'hFFF8, 16'h0000);

        // R1-style table on input 0; tag chosen by mode
        for (int k = 0; k < 8; k++) begin
            string tag;
            case (VECS[k].mode)
                2'b00: tag = "R1 edge";
                2'b01: tag = "R2 div8";
                2'b10: tag = "R3 div16";
                default: tag = "R4 div128";
            endcase
            wr(1'b0, {14'd0, VECS[k].mode});
            idle(5);
            clear_all();
            @(negedge clk) pin_n[0] = 1'b0;
            idle(int'(VECS[k].low));
            pin_n[0] = 1'b1;
            idle(5);
            rd(1'b1, rv);
            chk(tag, {15'd0, rv[0]}, {15'd0, VECS[k].exp});
        end
        wr(1'b0, 16'h0000);
        clear_all();

        // R7 interrupt gating
        @(negedge clk) pin_n[0] = 1'b0;
        idle(4); pin_n[0] = 1'b1; idle(2);
        #1 chk("R7 irq masked", {15'd0, irq}, 16'h0000);
        rd(1'b1, rv); chk("R7 flag sets while masked", rv & 16'h0001, 16'h0001);
        wr(1'b0, 16'h8000);
        #1 chk("R7 irq enabled", {15'd0, irq}, 16'h0001);
        clear_all();
        #1 chk("R7 irq drops", {15'd0, irq}, 16'h0000);
        wr(1'b0, 16'h0000);

        // R9 sticky clear rules
        @(negedge clk) pin_n[0] = 1'b0;
        idle(4); pin_n[0] = 1'b1; idle(2);
        wr(1'b1, 16'h0000);
        rd(1'b1, rv); chk("R9 write0 without read", rv & 16'h0001, 16'h0001);
        wr(1'b1, 16'hFFFF);
        rd(1'b1, rv); chk("R9 write1 no effect", rv & 16'h0001, 16'h0001);
        wr(1'b1, 16'h0000);
        rd(1'b1, rv); chk("R9 read then write0", rv & 16'h0001, 16'h0000);

        // R10 set beats clear on input 1 (edge mode)
        @(negedge clk) pin_n[1] = 1'b0;
        idle(4); pin_n[1] = 1'b1; idle(4);
        rd(1'b1, rv);
        @(negedge clk) pin_n[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h0000;
        @(negedge clk) reg_wr = 1'b0;
        pin_n[1] = 1'b1;
        idle(3);
        rd(1'b1, rv); chk("R10 set wins", rv & 16'h0002, 16'h0002);
        wr(1'b1, 16'h0000);
        rd(1'b1, rv); chk("R10 later clear", rv & 16'h0002, 16'h0000);

        // R6 independent modes: in0 div128, in1 edge, in2 div8
        wr(1'b0, 16'h0013);
        idle(3); clear_all();
        @(negedge clk) pin_n = '0;
        idle(150);
        pin_n = '1; idle(5);
        rd(1'b1, rv); chk("R6 mixed modes", rv, 16'h0006);
        clear_all();

        // R5 restart on high sample, then saturation (input 2, div8)
        wr(1'b0, 16'h0010);
        idle(3); clear_all();
        @(negedge clk) pin_n[2] = 1'b0;
        idle(80); pin_n[2] = 1'b1; idle(20); pin_n[2] = 1'b0; idle(80);
        rd(1'b1, rv); chk("R5 high restarts", rv & 16'h0004, 16'h0000);
        idle(200);
        rd(1'b1, rv); chk("R5 qualifies", rv & 16'h0004, 16'h0004);
        wr(1'b1, 16'h0000);
        idle(200);
        rd(1'b1, rv); chk("R5 saturates", rv & 16'h0004, 16'h0000);
        pin_n[2] = 1'b1; idle(20);

        // R11 mode change resets count and edge history
        wr(1'b0, 16'h0010);
        idle(3); clear_all();
        @(negedge clk) pin_n[2] = 1'b0;
        idle(100);
        wr(1'b0, 16'h0020);
        idle(120);
        rd(1'b1, rv); chk("R11 count reset", rv & 16'h0004, 16'h0000);
        wr(1'b0, 16'h0000);
        idle(10);
        rd(1'b1, rv); chk("R11 no edge on switch", rv & 16'h0004, 16'h0000);
        pin_n[2] = 1'b1; idle(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule